// File: doc/BRIEF.md
# UART Special Character Interrupt Unit

This unit sits on the receive side of a 16550-style UART. It compares every received byte with a programmable special character. When the two match, it raises a flag, and that flag is reported as an interrupt through the interrupt identification register. The matched byte is still captured like any other data byte. The flag does nothing to the transmit side: bytes written for transmission keep leaving while the flag is pending. Reading the identification register clears the flag.

Software reaches the match controls through a small register bank. A magic line-control value switches the bank into a configuration view. That view exposes the enhanced feature register and the special-character register. The XOFF interrupt enable bit in the interrupt enable register is writable only while the enhanced-functions bit is set. Received bytes arrive on a byte-valid strobe, and a one-byte holding register stands in for the receive FIFO. A loopback bit in the modem control register feeds bytes written for transmission straight into the receive path.

Top module: `uart_schar_intr`

## Requirements
- R1: After reset, LCR, MCR, IER, EFR and XOFF2 read 0x00, IIR reads 0x01 and irq_o is low.
- R2: With LCR = 0xBF (configuration view), address 2 reads and writes EFR and address 7 reads and writes XOFF2. Address 1 reads 0x00 and writes there are ignored. With any other LCR value (operational view), address 2 reads IIR and writes to it are ignored, and address 7 reads 0x00 and writes to it are ignored. Address 3 is LCR in both views.
- R3: In the operational view, address 1 is IER. IER bit 0 (receive data/timeout enable) is always writable. IER bit 5 (special-character enable) takes a write only while EFR bit 4 is 1; otherwise it keeps its old value.
- R4: While EFR bit 5 is 1, a received byte equal to XOFF2 sets the special-character flag. A byte that differs does not set it, and nothing sets it while EFR bit 5 is 0.
- R5: Every received byte, matched or not, is stored in the holding register. An operational read of address 0 returns that byte and clears data-ready.
- R6: IIR reads 0x0C when a timeout is pending. Otherwise it reads 0x04 when data is ready, otherwise 0x10 when the special-character flag is set, otherwise 0x01. A source counts only when its IER bit is set: bit 0 gates timeout and data, bit 5 gates the special character.
- R7: An operational read of address 2 clears the special-character flag. A match in the same cycle as that read leaves the flag set.
- R8: irq_o is high exactly when IIR bit 0 is 0.
- R9: With MCR bit 4 = 1 (loopback), an operational write to address 0 is received as a byte and tx_valid_o stays low. With MCR bit 4 = 0, the same write drives tx_valid_o high in that cycle, with the written value on tx_byte_o.
- R10: A pending special-character flag does not block transmission: tx_valid_o still follows writes to address 0.
- R11: A pulse on rx_tmo_i sets the timeout flag. An operational read of address 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effects at the clock edge) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| rx_valid_i | input | 1 | Received byte strobe from the deserializer |
| rx_byte_i | input | 8 | Received byte |
| rx_tmo_i | input | 1 | Receive timeout pulse from the idle counter |
| tx_valid_o | output | 1 | Byte to transmit |
| tx_byte_o | output | 8 | Transmit byte |
| irq_o | output | 1 | Interrupt request |

## Verification
A vector table varies the special character, the byte received and the detect enable. Together these cases separate the correct comparison from three faulty ones: a detector that ignores its enable, one that compares only some of the bits, and one that fires on any byte. Directed sequences pile up the timeout, data and special-character sources, so that each read of the identification register reveals the priority order and which source a read clears. Further cases cover a match that lands in the same cycle as the clearing read, loopback bytes against the direct transmit strobe, and IER bit 5 writes with the enhanced-functions bit both clear and set.

// File: rtl/uart_schar_pkg.sv
package uart_schar_pkg;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam logic [AW-1:0] A_DATA  = 3'd0;
  localparam logic [AW-1:0] A_IER   = 3'd1;
  localparam logic [AW-1:0] A_IIR   = 3'd2;
  localparam logic [AW-1:0] A_LCR   = 3'd3;
  localparam logic [AW-1:0] A_MCR   = 3'd4;
  localparam logic [AW-1:0] A_XOFF2 = 3'd7;
  localparam logic [DW-1:0] CFG_KEY = 8'hBF;
  localparam logic [DW-1:0] IIR_NONE = 8'h01;
  localparam logic [DW-1:0] IIR_TMO  = 8'h0C;
  localparam logic [DW-1:0] IIR_RXD  = 8'h04;
  localparam logic [DW-1:0] IIR_SCH  = 8'h10;
  localparam int IER_RX  = 0;
  localparam int IER_SCH = 5;
  localparam int EFR_ENH = 4;
  localparam int EFR_SCD = 5;
  localparam int MCR_LB  = 4;
endpackage

// File: rtl/uart_schar_regs.sv
module uart_schar_regs
  import uart_schar_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic          cfg_o,
  output logic [DW-1:0] lcr_o,
  output logic [DW-1:0] mcr_o,
  output logic [DW-1:0] efr_o,
  output logic [DW-1:0] xoff2_o,
  output logic [DW-1:0] ier_o
);
  logic [DW-1:0] ier_msk;

  assign cfg_o = (lcr_o == CFG_KEY);

  always_comb begin
    ier_msk = '1;
    if (!efr_o[EFR_ENH]) ier_msk[IER_SCH] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcr_o <= '0; mcr_o <= '0; efr_o <= '0; xoff2_o <= '0; ier_o <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_LCR) lcr_o <= wdata_i;
      if (cfg_o) begin
        if (addr_i == A_IIR)   efr_o   <= wdata_i;
        if (addr_i == A_XOFF2) xoff2_o <= wdata_i;
      end else begin
        if (addr_i == A_MCR) mcr_o <= wdata_i;
        if (addr_i == A_IER) ier_o <= (wdata_i & ier_msk) | (ier_o & ~ier_msk);
      end
    end
  end
endmodule

// File: rtl/uart_schar_rx.sv
module uart_schar_rx
  import uart_schar_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic [DW-1:0] byte_i,
  input  logic          rhr_rd_i,
  input  logic          tmo_i,
  output logic [DW-1:0] rhr_o,
  output logic          dr_o,
  output logic          tmo_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rhr_o <= '0; dr_o <= 1'b0; tmo_o <= 1'b0;
    end else begin
      if (fire_i) rhr_o <= byte_i;
      if (fire_i) dr_o <= 1'b1;
      else if (rhr_rd_i) dr_o <= 1'b0;
      if (tmo_i) tmo_o <= 1'b1;
      else if (rhr_rd_i) tmo_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_schar_match.sv
module uart_schar_match
  import uart_schar_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [DW-1:0] char_i,
  input  logic          fire_i,
  input  logic [DW-1:0] byte_i,
  input  logic          clr_i,
  output logic          hit_o,
  output logic          flag_o
);
  assign hit_o = en_i && fire_i && (byte_i == char_i);

  // set wins over a clearing read in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (hit_o)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/uart_schar_prio.sv
module uart_schar_prio
  import uart_schar_pkg::*;
(
  input  logic          tmo_i,
  input  logic          dr_i,
  input  logic          sch_i,
  input  logic [DW-1:0] ier_i,
  output logic [DW-1:0] iir_o,
  output logic          irq_o
);
  localparam int NSRC = 3;
  localparam logic [DW-1:0] CODES [NSRC] = '{IIR_TMO, IIR_RXD, IIR_SCH};
  logic [NSRC-1:0] pend;

  assign pend = {ier_i[IER_SCH] & sch_i, ier_i[IER_RX] & dr_i, ier_i[IER_RX] & tmo_i};
  assign irq_o = |pend;

  always_comb begin
    iir_o = IIR_NONE;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pend[i]) iir_o = CODES[i];
  end
endmodule

// File: rtl/uart_schar_intr.sv
module uart_schar_intr
  import uart_schar_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_byte_i,
  input  logic          rx_tmo_i,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_byte_o,
  output logic          irq_o
);
  logic          cfg;
  logic [DW-1:0] lcr, mcr, efr, xoff2, ier, rhr, iir;
  logic          loop_en, thr_wr, rhr_rd, iir_rd;
  logic          rx_fire, dr, tmo, sch_hit, sch_flag;
  logic [DW-1:0] rx_byte;

  assign loop_en = mcr[MCR_LB];
  assign thr_wr  = wr_en_i && !cfg && (addr_i == A_DATA);
  assign rhr_rd  = rd_en_i && !cfg && (addr_i == A_DATA);
  assign iir_rd  = rd_en_i && !cfg && (addr_i == A_IIR);
  assign rx_fire = loop_en ? thr_wr : rx_valid_i;
  assign rx_byte = loop_en ? wdata_i : rx_byte_i;
  assign tx_valid_o = thr_wr && !loop_en;
  assign tx_byte_o  = wdata_i;

  uart_schar_regs u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wdata_i,
    .cfg_o(cfg), .lcr_o(lcr), .mcr_o(mcr), .efr_o(efr), .xoff2_o(xoff2), .ier_o(ier)
  );

  uart_schar_rx u_rx (
    .clk_i, .rst_ni, .fire_i(rx_fire), .byte_i(rx_byte), .rhr_rd_i(rhr_rd),
    .tmo_i(rx_tmo_i), .rhr_o(rhr), .dr_o(dr), .tmo_o(tmo)
  );

  uart_schar_match u_match (
    .clk_i, .rst_ni, .en_i(efr[EFR_SCD]), .char_i(xoff2), .fire_i(rx_fire),
    .byte_i(rx_byte), .clr_i(iir_rd), .hit_o(sch_hit), .flag_o(sch_flag)
  );

  uart_schar_prio u_prio (
    .tmo_i(tmo), .dr_i(dr), .sch_i(sch_flag), .ier_i(ier), .iir_o(iir), .irq_o
  );

  always_comb begin
    rdata_o = '0;
    if (cfg) begin
      case (addr_i)
        A_IIR:   rdata_o = efr;
        A_LCR:   rdata_o = lcr;
        A_XOFF2: rdata_o = xoff2;
        default: rdata_o = '0;
      endcase
    end else begin
      case (addr_i)
        A_DATA:  rdata_o = rhr;
        A_IER:   rdata_o = ier;
        A_IIR:   rdata_o = iir;
        A_LCR:   rdata_o = lcr;
        A_MCR:   rdata_o = mcr;
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_schar_intr_chk.sv
module uart_schar_intr_chk
  import uart_schar_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          irq_o,
  input logic          tx_valid_o,
  input logic [DW-1:0] iir,
  input logic [DW-1:0] efr,
  input logic [DW-1:0] ier,
  input logic [DW-1:0] mcr,
  input logic [DW-1:0] xoff2,
  input logic          rx_fire,
  input logic [DW-1:0] rx_byte,
  input logic          iir_rd,
  input logic          sch_flag,
  input logic          tmo
);
  assert_irq_matches_iir_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == !iir[0]);

  assert_match_sets_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_fire && efr[EFR_SCD] && rx_byte == xoff2) |=> sch_flag);

  assert_no_match_no_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sch_flag && !(rx_fire && efr[EFR_SCD])) |=> !sch_flag);

  assert_read_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_rd && !(rx_fire && efr[EFR_SCD] && rx_byte == xoff2)) |=> !sch_flag);

  assert_ier5_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ier[IER_SCH]) |-> $past(efr[EFR_ENH]));

  assert_loop_no_tx_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcr[MCR_LB] |-> !tx_valid_o);

  assert_tmo_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir == IIR_TMO) |-> (tmo && ier[IER_RX]));
endmodule

bind uart_schar_intr uart_schar_intr_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_o(irq_o), .tx_valid_o(tx_valid_o),
  .iir(iir), .efr(efr), .ier(ier), .mcr(mcr), .xoff2(xoff2), .rx_fire(rx_fire),
  .rx_byte(rx_byte), .iir_rd(iir_rd), .sch_flag(sch_flag), .tmo(tmo)
);

// File: tb/uart_schar_intr_tb_top.sv
module uart_schar_intr_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_byte_i = '0;
  logic       rx_tmo_i = 1'b0;
  logic       tx_valid_o;
  logic [7:0] tx_byte_o;
  logic       irq_o;

  int n_chk = 0, n_bad = 0;
  logic [7:0] rv;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  uart_schar_intr dut_i (.*);

  // {xoff2, rx byte, detect enable, expected IIR}
  localparam int NV = 6;
  localparam logic [24:0] VEC [NV] = '{
    {8'h23, 8'h23, 1'b1, 8'h10},
    {8'h23, 8'h24, 1'b1, 8'h01},
    {8'h7F, 8'h7F, 1'b0, 8'h01},
    {8'h7F, 8'h7F, 1'b1, 8'h10},
    {8'hA5, 8'h25, 1'b1, 8'h01},
    {8'h00, 8'h00, 1'b1, 8'h10}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr_i = a; rd_en_i = 1'b1;
    #1 d = rdata_o;
    @(posedge clk_i); @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic rx(input logic [7:0] b);
    rx_byte_i = b; rx_valid_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    rx_valid_i = 1'b0;
  endtask

  task automatic cfg_set(input logic [7:0] efr, input logic [7:0] x2);
    wr(3'd3, 8'hBF); wr(3'd2, efr); wr(3'd7, x2); wr(3'd3, 8'h03);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(3'd2, rv); chk("R1 iir", rv, 8'h01);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
    rd(3'd1, rv); chk("R1 ier", rv, 8'h00);
    rd(3'd3, rv); chk("R1 lcr", rv, 8'h00);
    rd(3'd4, rv); chk("R1 mcr", rv, 8'h00);
    wr(3'd3, 8'hBF);
    rd(3'd2, rv); chk("R1 efr", rv, 8'h00);
    rd(3'd7, rv); chk("R1 xoff2", rv, 8'h00);
    wr(3'd3, 8'h00);

    // R3 IER bit 5 gated by EFR bit 4
    wr(3'd1, 8'h21);
    rd(3'd1, rv); chk("R3 ier gated", rv, 8'h01);
    cfg_set(8'h10, 8'h55);
    wr(3'd1, 8'h21);
    rd(3'd1, rv); chk("R3 ier open", rv, 8'h21);

    // R2 view mapping
    wr(3'd3, 8'hBF);
    wr(3'd1, 8'h00);
    rd(3'd1, rv); chk("R2 cfg addr1 read", rv, 8'h00);
    wr(3'd3, 8'h03);
    rd(3'd1, rv); chk("R2 cfg addr1 write ignored", rv, 8'h21);
    wr(3'd7, 8'hEE);
    rd(3'd7, rv); chk("R2 op addr7 read", rv, 8'h00);
    wr(3'd2, 8'hFF);
    wr(3'd3, 8'hBF);
    rd(3'd7, rv); chk("R2 xoff2 kept", rv, 8'h55);
    rd(3'd2, rv); chk("R2 efr kept", rv, 8'h10);
    wr(3'd3, 8'h03);

    // vector table: R4 R5 with IER = special char only
    wr(3'd1, 8'h20);
    for (int i = 0; i < NV; i++) begin
      cfg_set({2'b00, VEC[i][8], 5'b10000}, VEC[i][24:17]);
      rx(VEC[i][16:9]);
      chk("R4 irq", {7'd0, irq_o}, {7'd0, (VEC[i][7:0] == 8'h10)});
      rd(3'd2, rv); chk("R4 iir", rv, VEC[i][7:0]);
      rd(3'd0, rv); chk("R5 rhr", rv, VEC[i][16:9]);
      rd(3'd2, rv); chk("R7 cleared", rv, 8'h01);
    end

    // R6 priority, R11 timeout
    cfg_set(8'h30, 8'h5A);
    wr(3'd1, 8'h21);
    rx(8'h5A);
    rx_tmo_i = 1'b1; @(posedge clk_i); @(negedge clk_i); rx_tmo_i = 1'b0;
    chk("R8 irq", {7'd0, irq_o}, 8'h01);
    rd(3'd2, rv); chk("R6 tmo top", rv, 8'h0C);
    rd(3'd2, rv); chk("R6 tmo still", rv, 8'h0C);
    rd(3'd0, rv); chk("R11 rhr", rv, 8'h5A);
    rd(3'd2, rv); chk("R6 R7 after clear", rv, 8'h01);
    rx(8'h5A);
    rd(3'd2, rv); chk("R6 data over sch", rv, 8'h04);
    rx(8'h5A);
    rd(3'd0, rv);
    rd(3'd2, rv); chk("R6 sch alone", rv, 8'h10);
    chk("R8 irq low", {7'd0, irq_o}, 8'h00);

    // R7 match in same cycle as clearing read
    rx_byte_i = 8'h5A; rx_valid_i = 1'b1;
    rd(3'd2, rv);
    rx_valid_i = 1'b0;
    rd(3'd0, rv);
    rd(3'd2, rv); chk("R7 set wins", rv, 8'h10);

    // R10 tx not blocked by pending flag
    rx(8'h5A);
    rd(3'd0, rv);
    addr_i = 3'd0; wdata_i = 8'h41; wr_en_i = 1'b1;
    #1 chk("R10 tx valid", {7'd0, tx_valid_o}, 8'h01);
    chk("R9 tx byte", tx_byte_o, 8'h41);
    @(posedge clk_i); @(negedge clk_i); wr_en_i = 1'b0;
    rd(3'd2, rv); chk("R10 sch", rv, 8'h10);

    // R9 loopback
    wr(3'd4, 8'h10);
    addr_i = 3'd0; wdata_i = 8'h5A; wr_en_i = 1'b1;
    #1 chk("R9 no tx", {7'd0, tx_valid_o}, 8'h00);
    @(posedge clk_i); @(negedge clk_i); wr_en_i = 1'b0;
    rd(3'd2, rv); chk("R9 loop data", rv, 8'h04);
    rd(3'd0, rv); chk("R9 loop rhr", rv, 8'h5A);
    rd(3'd2, rv); chk("R9 loop sch", rv, 8'h01);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule